// File: doc/BRIEF.md
# Packet Address Classifier and Router

This block sits behind a receive character FIFO and looks at the start of each packet to decide where the packet goes. The first byte is a logical address, the second a protocol identifier and the third, for one protocol, a command byte. The block holds up to three leading bytes, compares the address with a set of DMA channels and a shared default address, and applies the remote-memory-access (RMAP) rules. It then reports one routing decision per packet: a channel index, the RMAP target, or discard.

After the decision, the held bytes are released in order. The rest of the packet follows through the same byte stream. The end marker is never forwarded; it appears only as a completion pulse with an error flag. A discarded packet is drained from the FIFO up to and including its end marker and produces no output bytes. Descriptor handling, memory writes and command execution belong to the blocks downstream.

Top module: `pkt_addr_router`

## Requirements
- R1: The address byte is compared with every enabled channel. The packet goes to the matching channel with the lowest index, reported as routeKind 1 with that index on routeChan.
- R2: An address bit is compared only where the selected mask has a 0. A mask bit of 1 means that bit may take any value.
- R3: A channel whose chanSep bit is 1 uses its own address and mask. A channel whose chanSep bit is 0 uses defAddr and defMask.
- R4: A channel whose chanEn bit is 0 never matches.
- R5: An RMAP command is a packet with protocol byte 0x01 and bit 6 of the third byte set, received while rmapEn is 1. If the default pair matches, it goes to the RMAP target (routeKind 2), even when a channel also matches.
- R6: An RMAP command that misses the default pair but matches a channel goes to that channel.
- R7: An RMAP command that matches neither the default pair nor any channel still goes to the RMAP target. With rmapEn at 0, the same packet is treated as ordinary traffic and is discarded.
- R8: A packet that is not an RMAP command and matches no channel is discarded (routeKind 0). No bytes and no completion pulse are produced, every character up to and including the end marker is consumed, and the next packet is routed normally.
- R9: With promiscuous mode off, a packet needs at least 2 data characters to be stored to a channel. A 1-character packet is discarded.
- R10: With promisc at 1, address comparison and the RMAP rules are skipped. Any packet with at least 1 data character goes to channel 0.
- R11: When rmapEn is 1 and the protocol byte is 0x01, fewer than 3 data characters means discard. With rmapEn at 0, a 2-character packet with that protocol byte goes to a matching channel.
- R12: On inData, bit 8 set marks an end marker, and then bit 0 is 0 for a normal end and 1 for an error end. For a routed packet, every data byte, address and protocol byte included, appears on outData in arrival order. The marker itself is never output. A one-cycle outDone pulse follows the last byte, with outErr equal to the marker's bit 0.
- R13: After reset, outValid, outDone and routeValid are 0 and inReady is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | FIFO holds a character |
| inData | input | 9 | Character: bit 8 is the end-marker flag; bit 0 of a marker selects normal (0) or error (1) end |
| inReady | output | 1 | Character is read at this edge when inValid is also 1 |
| chanAddr | input | 8*NUM_CHAN | Per-channel own address, channel i in bits 8i+7..8i |
| chanMask | input | 8*NUM_CHAN | Per-channel own mask, same layout |
| chanEn | input | NUM_CHAN | Channel enable |
| chanSep | input | NUM_CHAN | Channel uses its own pair (1) or the default pair (0) |
| defAddr | input | 8 | Shared default address |
| defMask | input | 8 | Shared default mask |
| rmapEn | input | 1 | RMAP target present and enabled |
| promisc | input | 1 | Promiscuous mode |
| routeValid | output | 1 | One-cycle pulse when a decision is made |
| routeKind | output | 2 | 0 discard, 1 channel, 2 RMAP target; held until the next decision |
| routeChan | output | CHAN_W | Channel index for routeKind 1 |
| outValid | output | 1 | outData carries a forwarded byte |
| outData | output | 8 | Forwarded byte |
| outDone | output | 1 | End of the forwarded packet |
| outErr | output | 1 | Packet ended with an error marker; valid with outDone |

## Verification
The routing decision and the packet's end can land in the same window. This happens when the end marker arrives before three header bytes have been collected, so the decision is taken on a short header and the packet finishes from buffered bytes alone. The bench provokes this with 1- and 2-character packets: with normal and error markers, with the RMAP protocol byte under both settings of rmapEn, and under promiscuous mode. For each packet it judges the number of decisions, the kind and index, the exact released byte list, and whether exactly one completion pulse follows with the right error flag. For discarded packets it checks that no byte and no pulse appear and that the following packet is unaffected.

// File: rtl/pkt_route_pkg.sv
package pkt_route_pkg;
  typedef enum logic [1:0] {
    RT_DROP = 2'd0,
    RT_CHAN = 2'd1,
    RT_RMAP = 2'd2
  } routeKind_t;

  localparam int          HDR_LEN  = 3;
  localparam logic [7:0]  RMAP_PID = 8'h01;
  localparam int          CMD_BIT  = 6;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic       capture;  // store inData into header slot
    logic [1:0] slot;
    logic       markEnd;  // latch end-marker type seen during header
    logic       decide;   // latch routing decision
    logic       emitBuf;  // emit held header byte
    logic [1:0] bufIdx;
    logic       emitIn;   // emit live input byte
    logic       emitEnd;  // emit completion pulse
    logic       endLive;  // completion type taken from live input
  } ctrlStrobe_t;
endpackage

// File: rtl/pkt_route_dp.sv
module pkt_route_dp
  import pkt_route_pkg::*;
#(
  parameter int NUM_CHAN = 4,
  parameter int CHAN_W   = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strb,
  input  logic [1:0]            byteCnt,
  input  logic [8:0]            inData,
  input  logic [8*NUM_CHAN-1:0] chanAddr,
  input  logic [8*NUM_CHAN-1:0] chanMask,
  input  logic [NUM_CHAN-1:0]   chanEn,
  input  logic [NUM_CHAN-1:0]   chanSep,
  input  logic [7:0]            defAddr,
  input  logic [7:0]            defMask,
  input  logic                  rmapEn,
  input  logic                  promisc,
  output routeKind_t            decKind,
  output logic                  routeValid,
  output routeKind_t            routeKind,
  output logic [CHAN_W-1:0]     routeChan,
  output logic                  outValid,
  output logic [7:0]            outData,
  output logic                  outDone,
  output logic                  outErr
);
  logic [7:0] hdr [HDR_LEN];
  logic       endErrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < HDR_LEN; k++) hdr[k] <= 8'h00;
      endErrQ <= 1'b0;
    end else begin
      for (int k = 0; k < HDR_LEN; k++)
        if (strb.capture && strb.slot == k[1:0]) hdr[k] <= inData[7:0];
      if (strb.markEnd) endErrQ <= inData[0];
    end
  end

  // Address comparison
  logic [NUM_CHAN-1:0] chanHit;
  logic                defHit;
  assign defHit = ((hdr[0] ^ defAddr) & ~defMask) == 8'h00;

  for (genvar gi = 0; gi < NUM_CHAN; gi++) begin : g_cmp
    logic [7:0] refAddr, refMask;
    assign refAddr    = chanSep[gi] ? chanAddr[gi*8 +: 8] : defAddr;
    assign refMask    = chanSep[gi] ? chanMask[gi*8 +: 8] : defMask;
    assign chanHit[gi] = chanEn[gi] && (((hdr[0] ^ refAddr) & ~refMask) == 8'h00);
  end

  logic [CHAN_W-1:0] firstIdx;
  always_comb begin
    firstIdx = '0;
    for (int i = NUM_CHAN - 1; i >= 0; i--)
      if (chanHit[i]) firstIdx = i[CHAN_W-1:0];
  end

  // Routing decision
  logic              rmapProto, rmapCmd, chanAny;
  logic [CHAN_W-1:0] decChan;
  assign chanAny   = |chanHit;
  assign rmapProto = rmapEn && (byteCnt >= 2'd2) && (hdr[1] == RMAP_PID);
  assign rmapCmd   = rmapProto && (byteCnt == 2'd3) && hdr[2][CMD_BIT];

  always_comb begin
    decKind = RT_DROP;
    decChan = firstIdx;
    if (promisc) begin
      decChan = '0;
      if (byteCnt != 2'd0) decKind = RT_CHAN;
    end else if (rmapProto && byteCnt != 2'd3) begin
      decKind = RT_DROP;
    end else if (rmapCmd) begin
      if (defHit)       decKind = RT_RMAP;
      else if (chanAny) decKind = RT_CHAN;
      else              decKind = RT_RMAP;
    end else if (chanAny && byteCnt >= 2'd2) begin
      decKind = RT_CHAN;
    end
  end

  logic [7:0] bufByte;
  always_comb begin
    bufByte = hdr[0];
    for (int k = 0; k < HDR_LEN; k++)
      if (strb.bufIdx == k[1:0]) bufByte = hdr[k];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      routeValid <= 1'b0;
      routeKind  <= RT_DROP;
      routeChan  <= '0;
      outValid   <= 1'b0;
      outData    <= 8'h00;
      outDone    <= 1'b0;
      outErr     <= 1'b0;
    end else begin
      routeValid <= strb.decide;
      if (strb.decide) begin
        routeKind <= decKind;
        routeChan <= decChan;
      end
      outValid <= strb.emitBuf | strb.emitIn;
      if (strb.emitBuf)     outData <= bufByte;
      else if (strb.emitIn) outData <= inData[7:0];
      outDone <= strb.emitEnd;
      outErr  <= strb.emitEnd & (strb.endLive ? inData[0] : endErrQ);
    end
  end

  a_r12_byte_or_done: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({outValid, outDone}));
  a_r10_promisc_chan0: assert property (@(posedge clk) disable iff (!rstN)
    (routeValid && $past(promisc)) |-> (routeChan == '0 && routeKind == RT_CHAN));
  a_r4_enabled_target: assert property (@(posedge clk) disable iff (!rstN)
    (routeValid && routeKind == RT_CHAN && !$past(promisc))
      |-> (($past(chanEn) & (NUM_CHAN'(1) << routeChan)) != '0));
  a_r7_rmap_needs_en: assert property (@(posedge clk) disable iff (!rstN)
    (routeValid && routeKind == RT_RMAP) |-> $past(rmapEn));
endmodule

// File: rtl/pkt_route_ctl.sv
module pkt_route_ctl
  import pkt_route_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [8:0]  inData,
  input  routeKind_t  decKind,
  output logic        inReady,
  output logic [1:0]  byteCnt,
  output ctrlStrobe_t strb
);
  typedef enum logic [2:0] {
    S_COLLECT, S_DECIDE, S_RELEASE, S_PASS, S_DROP
  } state_t;

  state_t     state;
  logic [1:0] cnt, relIdx;
  logic       endSeen;
  logic       accept, isMark;

  assign byteCnt = cnt;
  assign inReady = (state == S_COLLECT) || (state == S_PASS) || (state == S_DROP);
  assign accept  = inValid && inReady;
  assign isMark  = inData[8];

  always_comb begin
    strb = '0;
    case (state)
      S_COLLECT: if (accept) begin
        if (isMark) strb.markEnd = 1'b1;
        else begin
          strb.capture = 1'b1;
          strb.slot    = cnt;
        end
      end
      S_DECIDE: strb.decide = 1'b1;
      S_RELEASE: begin
        if (relIdx < cnt) begin
          strb.emitBuf = 1'b1;
          strb.bufIdx  = relIdx;
        end else strb.emitEnd = 1'b1;
      end
      S_PASS: if (accept) begin
        if (isMark) begin
          strb.emitEnd = 1'b1;
          strb.endLive = 1'b1;
        end else strb.emitIn = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_COLLECT;
      cnt     <= 2'd0;
      relIdx  <= 2'd0;
      endSeen <= 1'b0;
    end else begin
      case (state)
        S_COLLECT: if (accept) begin
          if (isMark) begin
            endSeen <= 1'b1;
            state   <= S_DECIDE;
          end else begin
            cnt <= cnt + 2'd1;
            if (cnt == 2'd2) state <= S_DECIDE;
          end
        end
        S_DECIDE: begin
          relIdx <= 2'd0;
          if (decKind == RT_DROP) begin
            cnt <= 2'd0;
            if (endSeen) begin
              endSeen <= 1'b0;
              state   <= S_COLLECT;
            end else state <= S_DROP;
          end else state <= S_RELEASE;
        end
        S_RELEASE: begin
          if (relIdx < cnt) begin
            relIdx <= relIdx + 2'd1;
            if (relIdx == cnt - 2'd1 && !endSeen) begin
              cnt   <= 2'd0;
              state <= S_PASS;
            end
          end else begin
            cnt     <= 2'd0;
            endSeen <= 1'b0;
            state   <= S_COLLECT;
          end
        end
        S_PASS: if (accept && isMark) state <= S_COLLECT;
        S_DROP: if (accept && isMark) state <= S_COLLECT;
        default: state <= S_COLLECT;
      endcase
    end
  end

  a_r9_header_full_decides: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_COLLECT && accept && !isMark && cnt == 2'd2) |=> (state == S_DECIDE));
  a_r8_drop_ends_on_marker: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DROP && accept && isMark) |=> (state == S_COLLECT && cnt == 2'd0));
  a_r12_release_blocks_input: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RELEASE) |-> (!strb.emitIn && !strb.capture));
endmodule

// File: rtl/pkt_addr_router.sv
module pkt_addr_router
  import pkt_route_pkg::*;
#(
  parameter  int NUM_CHAN = 4,
  localparam int CHAN_W   = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [8:0]            inData,
  output logic                  inReady,
  input  logic [8*NUM_CHAN-1:0] chanAddr,
  input  logic [8*NUM_CHAN-1:0] chanMask,
  input  logic [NUM_CHAN-1:0]   chanEn,
  input  logic [NUM_CHAN-1:0]   chanSep,
  input  logic [7:0]            defAddr,
  input  logic [7:0]            defMask,
  input  logic                  rmapEn,
  input  logic                  promisc,
  output logic                  routeValid,
  output logic [1:0]            routeKind,
  output logic [CHAN_W-1:0]     routeChan,
  output logic                  outValid,
  output logic [7:0]            outData,
  output logic                  outDone,
  output logic                  outErr
);
  ctrlStrobe_t strb;
  routeKind_t  decKind, kindQ;
  logic [1:0]  byteCnt;

  pkt_route_ctl u_ctl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .decKind(decKind), .inReady(inReady), .byteCnt(byteCnt), .strb(strb)
  );

  pkt_route_dp #(.NUM_CHAN(NUM_CHAN), .CHAN_W(CHAN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .byteCnt(byteCnt), .inData(inData),
    .chanAddr(chanAddr), .chanMask(chanMask), .chanEn(chanEn), .chanSep(chanSep),
    .defAddr(defAddr), .defMask(defMask), .rmapEn(rmapEn), .promisc(promisc),
    .decKind(decKind), .routeValid(routeValid), .routeKind(kindQ),
    .routeChan(routeChan), .outValid(outValid), .outData(outData),
    .outDone(outDone), .outErr(outErr)
  );

  assign routeKind = kindQ;
endmodule

// File: tb/sim_pkt_addr_router.sv
module sim_pkt_addr_router;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [8:0]    inData = '0;
  logic          inReady;
  logic [8*NC-1:0] chanAddr = '0, chanMask = '0;
  logic [NC-1:0] chanEn = '0, chanSep = '0;
  logic [7:0]    defAddr = '0, defMask = '0;
  logic          rmapEn = 1'b0, promisc = 1'b0;
  logic          routeValid, outValid, outDone, outErr;
  logic [1:0]    routeKind;
  logic [1:0]    routeChan;
  logic [7:0]    outData;

  always #2 clk = ~clk;

  pkt_addr_router #(.NUM_CHAN(NC)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inReady(inReady),
    .chanAddr(chanAddr), .chanMask(chanMask), .chanEn(chanEn), .chanSep(chanSep),
    .defAddr(defAddr), .defMask(defMask), .rmapEn(rmapEn), .promisc(promisc),
    .routeValid(routeValid), .routeKind(routeKind), .routeChan(routeChan),
    .outValid(outValid), .outData(outData), .outDone(outDone), .outErr(outErr)
  );

  int nRun = 0, nFail = 0;
  int routeCnt = 0, doneCnt = 0;
  logic [1:0] lastKind, lastChan;
  logic lastErr;
  logic [7:0] rxQ[$];
  logic [7:0] txQ[$];

  always @(negedge clk) if (rstN) begin
    if (outValid) rxQ.push_back(outData);
    if (outDone) begin doneCnt++; lastErr = outErr; end
    if (routeValid) begin routeCnt++; lastKind = routeKind; lastChan = routeChan; end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic sendChar(input logic [8:0] c);
    @(negedge clk);
    inValid = 1'b1; inData = c;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic setChan(input int i, input logic [7:0] a, input logic [7:0] m,
                         input logic en, input logic sep);
    chanAddr[i*8 +: 8] = a; chanMask[i*8 +: 8] = m;
    chanEn[i] = en; chanSep[i] = sep;
  endtask

  task automatic cfgClear();
    chanAddr = '0; chanMask = '0; chanEn = '0; chanSep = '0;
    defAddr = 8'h00; defMask = 8'h00; rmapEn = 1'b0; promisc = 1'b0;
  endtask

  // kind: 0 drop, 1 channel, 2 rmap
  task automatic sendAndCheck(input string req, input int expKind, input int expChan,
                              input logic eep);
    int r0, d0;
    r0 = routeCnt; d0 = doneCnt; rxQ.delete();
    foreach (txQ[i]) sendChar({1'b0, txQ[i]});
    sendChar({1'b1, 7'b0, eep});
    repeat (8) @(negedge clk);
    chk(req, "decisions", routeCnt - r0, 1);
    chk(req, "kind", int'(lastKind), expKind);
    if (expKind == 1) chk(req, "channel", int'(lastChan), expChan);
    if (expKind == 0) begin
      chk(req, "bytes out on discard", rxQ.size(), 0);
      chk(req, "done on discard", doneCnt - d0, 0);
    end else begin
      chk(req, "byte count", rxQ.size(), txQ.size());
      if (rxQ.size() == txQ.size())
        foreach (txQ[i]) chk(req, "byte value", int'(rxQ[i]), int'(txQ[i]));
      chk(req, "done pulses", doneCnt - d0, 1);
      chk(req, "error flag", int'(lastErr), int'(eep));
    end
  endtask

  task automatic tReset();
    chk("R13", "outValid", int'(outValid), 0);
    chk("R13", "outDone", int'(outDone), 0);
    chk("R13", "routeValid", int'(routeValid), 0);
    chk("R13", "inReady", int'(inReady), 1);
  endtask

  task automatic tFirstMatch();  // R1, R12
    cfgClear();
    setChan(0, 8'h21, 8'h00, 1, 1);
    setChan(1, 8'h20, 8'h00, 1, 1);
    setChan(2, 8'h20, 8'h00, 1, 1);
    txQ = '{8'h20, 8'h05, 8'hA1, 8'hB2, 8'hC3};
    sendAndCheck("R1", 1, 1, 1'b0);
  endtask

  task automatic tMask();  // R2, R8
    cfgClear();
    setChan(0, 8'h40, 8'h0F, 1, 1);
    txQ = '{8'h4A, 8'h10, 8'h11};
    sendAndCheck("R2", 1, 0, 1'b0);
    txQ = '{8'h5A, 8'h10, 8'h11, 8'h12, 8'h13, 8'h14};
    sendAndCheck("R8", 0, 0, 1'b0);
    txQ = '{8'h4F, 8'h22};
    sendAndCheck("R8", 1, 0, 1'b1);
  endtask

  task automatic tDefault();  // R3, R4
    cfgClear();
    defAddr = 8'h33;
    setChan(0, 8'h01, 8'h00, 1, 1);
    setChan(1, 8'h02, 8'h00, 1, 1);
    setChan(2, 8'h00, 8'hFF, 1, 0);
    txQ = '{8'h33, 8'h07, 8'h08};
    sendAndCheck("R3", 1, 2, 1'b0);
    chanEn[2] = 1'b0;
    sendAndCheck("R4", 0, 0, 1'b0);
  endtask

  task automatic tRmap();  // R5, R6, R7
    cfgClear();
    rmapEn = 1'b1; defAddr = 8'hFE;
    setChan(0, 8'h00, 8'h00, 1, 0);
    txQ = '{8'hFE, 8'h01, 8'h4C, 8'h00, 8'h01};
    sendAndCheck("R5", 2, 0, 1'b0);
    setChan(1, 8'h10, 8'h00, 1, 1);
    txQ = '{8'h10, 8'h01, 8'h4C, 8'h99};
    sendAndCheck("R6", 1, 1, 1'b0);
    txQ = '{8'h77, 8'h01, 8'h48, 8'h01};
    sendAndCheck("R7", 2, 0, 1'b0);
    rmapEn = 1'b0;
    sendAndCheck("R7", 0, 0, 1'b0);
  endtask

  task automatic tShort();  // R9, R11, R12
    cfgClear();
    setChan(3, 8'h55, 8'h00, 1, 1);
    txQ = '{8'h55};
    sendAndCheck("R9", 0, 0, 1'b0);
    txQ = '{8'h55, 8'h66};
    sendAndCheck("R12", 1, 3, 1'b1);
    txQ = '{8'h55, 8'h01};
    sendAndCheck("R11", 1, 3, 1'b0);
    rmapEn = 1'b1;
    sendAndCheck("R11", 0, 0, 1'b0);
    txQ = '{8'h55, 8'h02, 8'h40};
    sendAndCheck("R11", 1, 3, 1'b1);
  endtask

  task automatic tPromisc();  // R10
    cfgClear();
    promisc = 1'b1; rmapEn = 1'b1;
    setChan(2, 8'h99, 8'h00, 1, 1);
    txQ = '{8'h99};
    sendAndCheck("R10", 1, 0, 1'b1);
    txQ = '{8'hFE, 8'h01, 8'h4C, 8'h00};
    sendAndCheck("R10", 1, 0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tFirstMatch();
    tMask();
    tDefault();
    tRmap();
    tShort();
    tPromisc();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule